// File: doc/BRIEF.md
# Prefixed Opcode Execution Unit

This block executes the second-prefix opcode group of an 8-bit accumulator CPU that keeps two stack pointers, U and S. An operand-fetch stage hands it the sub-opcode that followed the prefix byte, the current U, S and condition-code registers, a 16-bit operand that has already been fetched, and the number of extra cycles the indexed addressing calculation cost. One cycle later the block presents the new condition codes, the instruction's cycle count and a completion pulse. Undefined sub-opcodes raise a one-cycle illegal strobe instead.

The group holds two 16-bit compares (U or S against the operand) and an add-to-U whose sum is thrown away and only shapes the flags. It also holds two software traps. For a trap the block produces a request for the exception sequencer: a one-cycle pulse plus held indications of whether E must be set, that the full machine state must be pushed, and the 16-bit vector address from which PC is loaded. This block writes no register other than the condition codes. Stack pushes, memory access and address calculation belong to neighbouring units.

Top module: `pfx2_exec_unit`

## Requirements
- R1: A sub-opcode with low nibble 0x3 and high nibble 0x8 to 0xB compares U with the operand, computing U minus operand. Condition-code bit positions are E=7, F=6, H=5, I=4, N=3, Z=2, V=1, C=0. The outputs are N = result bit 15, Z = result zero, V = signed overflow and C = borrow. Bits E, F, H and I pass through unchanged.
- R2: A sub-opcode with low nibble 0xC and high nibble 0x8 to 0xB compares S in the same way, with the same flag rules as R1.
- R3: A sub-opcode with low nibble 0x3 and high nibble 0xC to 0xF adds the operand to (U OR 0xFF00). N and Z come from the 16-bit sum, C is the carry out of bit 15, and V is set when both addends share a sign that the sum lacks. E, F, H and I pass through unchanged, and the sum is not output.
- R4: For R1 to R3 the high nibble picks the addressing mode: 0x8 and 0xC immediate (5 cycles), 0x9 and 0xD direct (7), 0xA and 0xE indexed (7 plus the extra-cycle input), 0xB and 0xF extended (8).
- R5: Sub-opcode 0x3F returns the input condition codes with bit 7 (E) set and I/F unchanged. It pulses the trap request with set-E=1 and push=1, drives vector 0xFFF2, and costs 20 cycles.
- R6: Sub-opcode 0x3E returns the input condition codes unchanged. It pulses the trap request with set-E=0 and push=1, drives vector 0xFFF6, and costs 20 cycles.
- R7: Every other sub-opcode pulses the illegal strobe, costs 2 cycles, returns the condition codes unchanged and raises no trap request. For every non-trap sub-opcode, set-E and push are 0 and the vector is 0x0000.
- R8: An operation is captured on each clock edge where operand-valid is high. Done is high in exactly the following cycle, and operations may arrive back to back. Without operand-valid, the condition codes, cycle count and trap outputs hold their values and done, illegal and trap request stay low.
- R9: While reset is asserted, done, illegal and trap request are low, and the condition codes, cycle count, set-E, push and vector are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Sub-opcode and operand are valid this cycle |
| sub_op_i | input | 8 | Sub-opcode following the prefix byte |
| reg_u_i | input | WORD_W | Current U stack pointer |
| reg_s_i | input | WORD_W | Current S stack pointer |
| cc_i | input | 8 | Current condition-code register |
| operand_i | input | WORD_W | Fetched 16-bit operand |
| idx_extra_i | input | XTRA_W | Extra cycles reported by the indexed address calculation |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 8 | Updated condition codes |
| cycles_o | output | CYC_W | Cycle count of the instruction |
| illegal_o | output | 1 | One-cycle illegal sub-opcode strobe |
| trap_req_o | output | 1 | One-cycle trap request pulse |
| trap_set_e_o | output | 1 | Trap asks for E to be set |
| trap_push_o | output | 1 | Trap asks for a full-state push |
| trap_vec_o | output | WORD_W | Vector address for loading PC |

## Verification
Two things can fall into the same cycle. One is the completion of one operation, with its done pulse, held flags and possibly a trap or illegal strobe. The other is the capture of the next operation, because operand-valid may stay high on consecutive edges. The bench drives traps, illegal codes and compares back to back with no gap. It then checks that each cycle's done, strobes, flags and vector belong to the operation captured on the edge just before. A behavioural model compares every output on every cycle, including idle cycles in which the inputs are scrambled to show the held results do not move.

// File: rtl/pfx2_pkg.sv
package pfx2_pkg;

  // condition-code bit positions
  localparam int unsigned CCB_C = 0;
  localparam int unsigned CCB_V = 1;
  localparam int unsigned CCB_Z = 2;
  localparam int unsigned CCB_N = 3;
  localparam int unsigned CCB_E = 7;
  localparam int unsigned CC_W  = 8;

  typedef enum logic [2:0] {
    OPK_CMP_U,
    OPK_CMP_S,
    OPK_ADD_U,
    OPK_TRAP_SWI3,
    OPK_TRAP_FIRQ,
    OPK_ILLEGAL
  } op_kind_e;

  typedef enum logic [1:0] {
    AM_IMM,
    AM_DIR,
    AM_IDX,
    AM_EXT
  } addr_mode_e;

  typedef struct packed {
    op_kind_e   kind;
    addr_mode_e mode;
  } dec_t;

endpackage

// File: rtl/pfx2_decode.sv
module pfx2_decode
  import pfx2_pkg::*;
(
  input  logic [7:0] sub_i,
  output dec_t       dec_o
);

  logic [3:0] hi_nib;
  logic [3:0] lo_nib;

  assign hi_nib = sub_i[7:4];
  assign lo_nib = sub_i[3:0];

  always_comb begin
    dec_o.kind = OPK_ILLEGAL;
    // mode follows the low two bits of the high nibble
    dec_o.mode = addr_mode_e'(hi_nib[1:0]);
    if (sub_i == 8'h3F) begin
      dec_o.kind = OPK_TRAP_SWI3;
    end else if (sub_i == 8'h3E) begin
      dec_o.kind = OPK_TRAP_FIRQ;
    end else if (hi_nib[3]) begin
      if (!hi_nib[2]) begin
        if (lo_nib == 4'h3) begin
          dec_o.kind = OPK_CMP_U;
        end else if (lo_nib == 4'hC) begin
          dec_o.kind = OPK_CMP_S;
        end
      end else if (lo_nib == 4'h3) begin
        dec_o.kind = OPK_ADD_U;
      end
    end
  end

endmodule

// File: rtl/pfx2_flag_alu.sv
module pfx2_flag_alu
  import pfx2_pkg::*;
#(
  parameter int unsigned       WORD_W  = 16,
  parameter logic [WORD_W-1:0] U_FORCE = 16'hFF00
) (
  input  op_kind_e          kind_i,
  input  logic [WORD_W-1:0] u_i,
  input  logic [WORD_W-1:0] s_i,
  input  logic [WORD_W-1:0] opd_i,
  input  logic [CC_W-1:0]   cc_i,
  output logic [CC_W-1:0]   cc_o
);

  localparam int unsigned MSB = WORD_W - 1;

  logic [WORD_W-1:0] lhs;
  logic [WORD_W:0]   diff;
  logic [WORD_W:0]   sum;

  always_comb begin
    unique case (kind_i)
      OPK_CMP_S: lhs = s_i;
      OPK_ADD_U: lhs = u_i | U_FORCE;
      default:   lhs = u_i;
    endcase
  end

  assign diff = {1'b0, lhs} - {1'b0, opd_i};
  assign sum  = {1'b0, lhs} + {1'b0, opd_i};

  always_comb begin
    cc_o = cc_i;
    unique case (kind_i)
      OPK_CMP_U, OPK_CMP_S: begin
        cc_o[CCB_N] = diff[MSB];
        cc_o[CCB_Z] = ~|diff[MSB:0];
        cc_o[CCB_V] = (lhs[MSB] ^ opd_i[MSB]) & (lhs[MSB] ^ diff[MSB]);
        cc_o[CCB_C] = diff[WORD_W];
      end
      OPK_ADD_U: begin
        cc_o[CCB_N] = sum[MSB];
        cc_o[CCB_Z] = ~|sum[MSB:0];
        cc_o[CCB_V] = ~(lhs[MSB] ^ opd_i[MSB]) & (lhs[MSB] ^ sum[MSB]);
        cc_o[CCB_C] = sum[WORD_W];
      end
      OPK_TRAP_SWI3: cc_o[CCB_E] = 1'b1;
      default: cc_o = cc_i;
    endcase
  end

endmodule

// File: rtl/pfx2_cycle_calc.sv
module pfx2_cycle_calc
  import pfx2_pkg::*;
#(
  parameter int unsigned CYC_W    = 8,
  parameter int unsigned XTRA_W   = 4,
  parameter int unsigned CYC_IMM  = 5,
  parameter int unsigned CYC_DIR  = 7,
  parameter int unsigned CYC_IDX  = 7,
  parameter int unsigned CYC_EXT  = 8,
  parameter int unsigned CYC_TRAP = 20,
  parameter int unsigned CYC_BAD  = 2
) (
  input  op_kind_e          kind_i,
  input  addr_mode_e        mode_i,
  input  logic [XTRA_W-1:0] extra_i,
  output logic [CYC_W-1:0]  cyc_o
);

  logic [CYC_W-1:0] mode_cyc;

  always_comb begin
    unique case (mode_i)
      AM_IMM:  mode_cyc = CYC_W'(CYC_IMM);
      AM_DIR:  mode_cyc = CYC_W'(CYC_DIR);
      AM_IDX:  mode_cyc = CYC_W'(CYC_IDX) + CYC_W'(extra_i);
      default: mode_cyc = CYC_W'(CYC_EXT);
    endcase
  end

  always_comb begin
    unique case (kind_i)
      OPK_TRAP_SWI3, OPK_TRAP_FIRQ: cyc_o = CYC_W'(CYC_TRAP);
      OPK_ILLEGAL:                  cyc_o = CYC_W'(CYC_BAD);
      default:                      cyc_o = mode_cyc;
    endcase
  end

endmodule

// File: rtl/pfx2_trap_req.sv
module pfx2_trap_req
  import pfx2_pkg::*;
#(
  parameter int unsigned       WORD_W   = 16,
  parameter logic [WORD_W-1:0] VEC_SWI3 = 16'hFFF2,
  parameter logic [WORD_W-1:0] VEC_FIRQ = 16'hFFF6
) (
  input  op_kind_e          kind_i,
  output logic              is_trap_o,
  output logic              set_e_o,
  output logic              push_o,
  output logic [WORD_W-1:0] vec_o
);

  always_comb begin
    is_trap_o = 1'b0;
    set_e_o   = 1'b0;
    push_o    = 1'b0;
    vec_o     = '0;
    unique case (kind_i)
      OPK_TRAP_SWI3: begin
        is_trap_o = 1'b1;
        set_e_o   = 1'b1;
        push_o    = 1'b1;
        vec_o     = VEC_SWI3;
      end
      OPK_TRAP_FIRQ: begin
        is_trap_o = 1'b1;
        push_o    = 1'b1;
        vec_o     = VEC_FIRQ;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pfx2_exec_unit.sv
module pfx2_exec_unit
  import pfx2_pkg::*;
#(
  parameter int unsigned       WORD_W   = 16,
  parameter int unsigned       CYC_W    = 8,
  parameter int unsigned       XTRA_W   = 4,
  parameter int unsigned       CYC_IMM  = 5,
  parameter int unsigned       CYC_DIR  = 7,
  parameter int unsigned       CYC_IDX  = 7,
  parameter int unsigned       CYC_EXT  = 8,
  parameter int unsigned       CYC_TRAP = 20,
  parameter int unsigned       CYC_BAD  = 2,
  parameter logic [WORD_W-1:0] U_FORCE  = 16'hFF00,
  parameter logic [WORD_W-1:0] VEC_SWI3 = 16'hFFF2,
  parameter logic [WORD_W-1:0] VEC_FIRQ = 16'hFFF6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [7:0]        sub_op_i,
  input  logic [WORD_W-1:0] reg_u_i,
  input  logic [WORD_W-1:0] reg_s_i,
  input  logic [7:0]        cc_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic [XTRA_W-1:0] idx_extra_i,
  output logic              done_o,
  output logic [7:0]        cc_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              illegal_o,
  output logic              trap_req_o,
  output logic              trap_set_e_o,
  output logic              trap_push_o,
  output logic [WORD_W-1:0] trap_vec_o
);

  dec_t              dec;
  logic [CC_W-1:0]   cc_nx;
  logic [CYC_W-1:0]  cyc_nx;
  logic              is_trap;
  logic              set_e_nx;
  logic              push_nx;
  logic [WORD_W-1:0] vec_nx;

  logic              done_d,  done_q;
  logic              ill_d,   ill_q;
  logic              trap_d,  trap_q;
  logic              cap_en;
  logic [CC_W-1:0]   cc_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              set_e_q, push_q;
  logic [WORD_W-1:0] vec_q;

  pfx2_decode u_decode (
    .sub_i (sub_op_i),
    .dec_o (dec)
  );

  pfx2_flag_alu #(
    .WORD_W  (WORD_W),
    .U_FORCE (U_FORCE)
  ) u_alu (
    .kind_i (dec.kind),
    .u_i    (reg_u_i),
    .s_i    (reg_s_i),
    .opd_i  (operand_i),
    .cc_i   (cc_i),
    .cc_o   (cc_nx)
  );

  pfx2_cycle_calc #(
    .CYC_W    (CYC_W),
    .XTRA_W   (XTRA_W),
    .CYC_IMM  (CYC_IMM),
    .CYC_DIR  (CYC_DIR),
    .CYC_IDX  (CYC_IDX),
    .CYC_EXT  (CYC_EXT),
    .CYC_TRAP (CYC_TRAP),
    .CYC_BAD  (CYC_BAD)
  ) u_cycles (
    .kind_i  (dec.kind),
    .mode_i  (dec.mode),
    .extra_i (idx_extra_i),
    .cyc_o   (cyc_nx)
  );

  pfx2_trap_req #(
    .WORD_W   (WORD_W),
    .VEC_SWI3 (VEC_SWI3),
    .VEC_FIRQ (VEC_FIRQ)
  ) u_trap (
    .kind_i    (dec.kind),
    .is_trap_o (is_trap),
    .set_e_o   (set_e_nx),
    .push_o    (push_nx),
    .vec_o     (vec_nx)
  );

  // next-state
  always_comb begin
    cap_en = op_valid_i;
    done_d = op_valid_i;
    ill_d  = op_valid_i && (dec.kind == OPK_ILLEGAL);
    trap_d = op_valid_i && is_trap;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      trap_q  <= 1'b0;
      cc_q    <= '0;
      cyc_q   <= '0;
      set_e_q <= 1'b0;
      push_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      done_q <= done_d;
      ill_q  <= ill_d;
      trap_q <= trap_d;
      if (cap_en) begin
        cc_q    <= cc_nx;
        cyc_q   <= cyc_nx;
        set_e_q <= set_e_nx;
        push_q  <= push_nx;
        vec_q   <= vec_nx;
      end
    end
  end

  assign done_o       = done_q;
  assign illegal_o    = ill_q;
  assign trap_req_o   = trap_q;
  assign cc_o         = cc_q;
  assign cycles_o     = cyc_q;
  assign trap_set_e_o = set_e_q;
  assign trap_push_o  = push_q;
  assign trap_vec_o   = vec_q;

endmodule

// File: rtl/pfx2_exec_unit_chk.sv
module pfx2_exec_unit_chk #(
  parameter int unsigned       WORD_W   = 16,
  parameter int unsigned       CYC_W    = 8,
  parameter int unsigned       CYC_TRAP = 20,
  parameter int unsigned       CYC_BAD  = 2,
  parameter logic [WORD_W-1:0] VEC_SWI3 = 16'hFFF2,
  parameter logic [WORD_W-1:0] VEC_FIRQ = 16'hFFF6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid_i,
  input logic [7:0]        cc_i,
  input logic              done_o,
  input logic [7:0]        cc_o,
  input logic [CYC_W-1:0]  cycles_o,
  input logic              illegal_o,
  input logic              trap_req_o,
  input logic              trap_set_e_o,
  input logic              trap_push_o,
  input logic [WORD_W-1:0] trap_vec_o
);

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> done_o); // R8
  AST_DONE_ONLY_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> (!done_o && !illegal_o && !trap_req_o)); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> ($stable(cc_o) && $stable(cycles_o) && $stable(trap_vec_o))); // R8
  AST_BAD_COST: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (done_o && !trap_req_o && cycles_o == CYC_W'(CYC_BAD))); // R7
  AST_BAD_CC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (cc_o == $past(cc_i))); // R7
  AST_TRAP_COST: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> (done_o && trap_push_o && cycles_o == CYC_W'(CYC_TRAP))); // R5
  AST_SWI3_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_o && trap_set_e_o) |-> (trap_vec_o == VEC_SWI3 && cc_o[7])); // R5
  AST_FIRQ_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_o && !trap_set_e_o) |-> (trap_vec_o == VEC_FIRQ && cc_o == $past(cc_i))); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!done_o && !illegal_o && !trap_req_o)); // R9

endmodule

bind pfx2_exec_unit pfx2_exec_unit_chk #(
  .WORD_W   (WORD_W),
  .CYC_W    (CYC_W),
  .CYC_TRAP (CYC_TRAP),
  .CYC_BAD  (CYC_BAD),
  .VEC_SWI3 (VEC_SWI3),
  .VEC_FIRQ (VEC_FIRQ)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid_i   (op_valid_i),
  .cc_i         (cc_i),
  .done_o       (done_o),
  .cc_o         (cc_o),
  .cycles_o     (cycles_o),
  .illegal_o    (illegal_o),
  .trap_req_o   (trap_req_o),
  .trap_set_e_o (trap_set_e_o),
  .trap_push_o  (trap_push_o),
  .trap_vec_o   (trap_vec_o)
);

// File: tb/pfx2_exec_unit_tb.sv
`timescale 1ns/1ps
module pfx2_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  sub_op;
  logic [15:0] reg_u, reg_s, operand;
  logic [7:0]  cc_in;
  logic [3:0]  idx_extra;
  logic        done, illegal, trap_req, set_e, push;
  logic [7:0]  cc_out, cycles;
  logic [15:0] vec;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // expected state
  int    e_done, e_ill, e_trap, e_cc, e_cyc, e_vec, e_sete, e_push;
  string e_tag, e_ctag;

  always #10 clk = ~clk;

  pfx2_exec_unit u_dut (
    .clk (clk), .rst_n (rst_n), .op_valid_i (op_valid), .sub_op_i (sub_op),
    .reg_u_i (reg_u), .reg_s_i (reg_s), .cc_i (cc_in), .operand_i (operand),
    .idx_extra_i (idx_extra), .done_o (done), .cc_o (cc_out), .cycles_o (cycles),
    .illegal_o (illegal), .trap_req_o (trap_req), .trap_set_e_o (set_e),
    .trap_push_o (push), .trap_vec_o (vec)
  );

  task automatic model_op(input int sub, input int u, input int s, input int cc,
                          input int opd, input int extra);
    int hi, lo, a, r, full, n, z, v, c, mcyc;
    hi = sub >> 4;
    lo = sub & 15;
    e_sete = 0; e_push = 0; e_vec = 0;
    case (hi % 4)
      0: mcyc = 5;
      1: mcyc = 7;
      2: mcyc = 7 + extra;
      default: mcyc = 8;
    endcase
    if (sub == 'h3F) begin
      e_tag = "R5"; e_ctag = "R5";
      e_cc = cc | 'h80; e_cyc = 20; e_trap = 1; e_sete = 1; e_push = 1; e_vec = 'hFFF2;
    end else if (sub == 'h3E) begin
      e_tag = "R6"; e_ctag = "R6";
      e_cc = cc; e_cyc = 20; e_trap = 1; e_push = 1; e_vec = 'hFFF6;
    end else if (hi >= 8 && hi <= 11 && (lo == 3 || lo == 12)) begin
      e_tag = (lo == 3) ? "R1" : "R2"; e_ctag = "R4";
      a = (lo == 3) ? u : s;
      r = (a - opd) & 'hFFFF;
      c = (a < opd) ? 1 : 0;
      v = (((a ^ opd) & (a ^ r)) >> 15) & 1;
      n = (r >> 15) & 1;
      z = (r == 0) ? 1 : 0;
      e_cc = (cc & 'hF0) | (n << 3) | (z << 2) | (v << 1) | c;
      e_cyc = mcyc;
    end else if (hi >= 12 && lo == 3) begin
      e_tag = "R3"; e_ctag = "R4";
      a = u | 'hFF00;
      full = a + opd;
      r = full & 'hFFFF;
      c = (full >> 16) & 1;
      v = (((~(a ^ opd)) & (a ^ r)) >> 15) & 1;
      n = (r >> 15) & 1;
      z = (r == 0) ? 1 : 0;
      e_cc = (cc & 'hF0) | (n << 3) | (z << 2) | (v << 1) | c;
      e_cyc = mcyc;
    end else begin
      e_tag = "R7"; e_ctag = "R7";
      e_cc = cc; e_cyc = 2; e_ill = 1;
    end
  endtask

  // cycle-by-cycle reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_done = 0; e_ill = 0; e_trap = 0; e_cc = 0; e_cyc = 0;
      e_vec = 0; e_sete = 0; e_push = 0; e_tag = "R9"; e_ctag = "R9";
    end else begin
      e_done = op_valid ? 1 : 0;
      e_ill = 0;
      e_trap = 0;
      if (op_valid)
        model_op(int'(sub_op), int'(reg_u), int'(reg_s), int'(cc_in),
                 int'(operand), int'(idx_extra));
      else begin
        e_tag = "R8"; e_ctag = "R8";
      end
    end
  end

  bit cyc_bad;

  task automatic cmp_field(input string name, input int act, input int exp, input string tag);
    if (act != exp) begin
      cyc_bad = 1'b1;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      string t_ctl, t_ill, t_val, t_cyc;
      cyc_bad = 1'b0;
      t_ctl = (!rst_n) ? "R9" : "R8";
      t_ill = (!rst_n) ? "R9" : "R7";
      t_val = (!rst_n) ? "R9" : e_tag;
      t_cyc = (!rst_n) ? "R9" : e_ctag;
      cmp_field("done",    int'(done),     e_done, t_ctl);
      cmp_field("illegal", int'(illegal),  e_ill,  t_ill);
      cmp_field("trapreq", int'(trap_req), e_trap, t_val);
      cmp_field("cc",      int'(cc_out),   e_cc,   t_val);
      cmp_field("cycles",  int'(cycles),   e_cyc,  t_cyc);
      cmp_field("vector",  int'(vec),      e_vec,  t_val);
      cmp_field("set_e",   int'(set_e),    e_sete, t_val);
      cmp_field("push",    int'(push),     e_push, t_val);
      vectors++;
      if (cyc_bad) miscompares++;
    end
  end

  task automatic scramble();
    sub_op    = 8'($urandom);
    reg_u     = 16'($urandom);
    reg_s     = 16'($urandom);
    cc_in     = 8'($urandom);
    operand   = 16'($urandom);
    idx_extra = 4'($urandom);
  endtask

  // drive at a falling edge: one valid cycle, then idle cycles with scrambled inputs
  task automatic apply(input logic [7:0] sub, input logic [15:0] u, input logic [15:0] s,
                       input logic [7:0] cc, input logic [15:0] opd, input logic [3:0] xt,
                       input int gap);
    sub_op = sub; reg_u = u; reg_s = s; cc_in = cc; operand = opd; idx_extra = xt;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    for (int i = 0; i < gap; i++) begin
      scramble();
      @(negedge clk);
    end
  endtask

  task automatic end_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R8 watchdog: actual run still busy, expected finished");
      end_run();
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0;
    sub_op = '0; reg_u = '0; reg_s = '0; cc_in = '0; operand = '0; idx_extra = '0;
    repeat (3) @(negedge clk);          // R9 reset state compared here
    rst_n = 1'b1;
    @(negedge clk);

    // R1 equal -> Z, then signed overflow 0x8000-1
    apply(8'h83, 16'h1234, 16'h0000, 8'h00, 16'h1234, 4'd0, 1);
    apply(8'h93, 16'h8000, 16'h0000, 8'hF0, 16'h0001, 4'd0, 1);
    // R2 borrow and negative
    apply(8'h8C, 16'h0000, 16'h0001, 8'h00, 16'h0002, 4'd0, 1);
    apply(8'hBC, 16'h0000, 16'h7FFF, 8'h2F, 16'hFFFF, 4'd0, 2);
    // R3 carry to zero, and overflow with carry
    apply(8'hC3, 16'h00FF, 16'h0000, 8'h00, 16'h0001, 4'd0, 1);
    apply(8'hD3, 16'h0000, 16'h0000, 8'h00, 16'h8000, 4'd0, 1);
    apply(8'hF3, 16'h1234, 16'h0000, 8'hA5, 16'h00CB, 4'd0, 1);
    // R4 indexed extra cycles
    apply(8'hE3, 16'h4000, 16'h0000, 8'h00, 16'h0100, 4'd5, 1);
    apply(8'hAC, 16'h0000, 16'h4000, 8'h00, 16'h4000, 4'd15, 1);
    apply(8'hA3, 16'h0000, 16'h0000, 8'h00, 16'h0000, 4'd0, 1);
    // R5 / R6 traps
    apply(8'h3F, 16'h0000, 16'h0000, 8'h50, 16'h0000, 4'd0, 2);
    apply(8'h3E, 16'h0000, 16'h0000, 8'h7F, 16'h0000, 4'd0, 2);
    // R7 undefined codes
    apply(8'h00, 16'h0000, 16'h0000, 8'h3C, 16'h0000, 4'd0, 1);
    apply(8'hFF, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 4'd0, 1);
    apply(8'hCC, 16'h0000, 16'h0000, 8'h11, 16'h0000, 4'd0, 1);
    apply(8'h3D, 16'h0000, 16'h0000, 8'h22, 16'h0000, 4'd0, 1);
    // R8 back-to-back: completion and next capture in the same cycle
    apply(8'h3F, 16'h0000, 16'h0000, 8'h00, 16'h0000, 4'd0, 0);
    apply(8'h83, 16'h0005, 16'h0000, 8'h80, 16'h0009, 4'd0, 0);
    apply(8'h3E, 16'h0000, 16'h0000, 8'h55, 16'h0000, 4'd0, 0);
    apply(8'h12, 16'h0000, 16'h0000, 8'hAA, 16'h0000, 4'd0, 0);
    apply(8'hE3, 16'h00FF, 16'h0000, 8'h0F, 16'h0001, 4'd3, 3);

    // sweep of every sub-opcode with random data and gaps
    for (int k = 0; k < 256; k++) begin
      apply(8'(k), 16'($urandom), 16'($urandom), 8'($urandom), 16'($urandom),
            4'($urandom), int'($urandom % 3));
    end

    // R9 reset in the middle of traffic
    sub_op = 8'h3F; op_valid = 1'b1;
    @(negedge clk);
    #3 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    op_valid = 1'b0;
    #3 rst_n = 1'b1;
    @(negedge clk);
    apply(8'hB3, 16'hFFFF, 16'h0000, 8'h00, 16'h0000, 4'd0, 2);
    end_run();
  end

endmodule